// File: doc/BRIEF.md
# Packet-Aware Cell Queue with Head Drop

This block buffers fixed-size cells that together form variable-length packets. A producer pushes one cell per cycle and flags the final cell of each packet. A consumer pulls cells out back to back. Storage is a ring of cells plus a smaller ring of packet descriptors. Each descriptor holds the cell address where a packet begins. A descriptor is entered only once a packet's final cell has been stored, so the consumer never sees a packet that is still arriving.

There are two ways a packet is lost. If an arriving packet finds the cell ring full, or finds no free descriptor when it completes, the fill side rewinds its write pointer to the start of that packet. It then ignores the rest of that packet. This is a tail drop.

The consumer side can also skip a whole queued packet. It makes this decision in the cycle that sends the final cell of the current packet. It then loads the read pointer from the descriptor two packets ahead, so no idle cycle is inserted. This is a head drop. A simple built-in policy, gated by an input, takes every other eligible skip while the queue is more than half full.

Top module: `cell_pkt_queue`

## Requirements
- R1: After reset the queue is empty: `out_valid` is 0 and `cell_count` is 0.
- R2: Accepted packets leave in arrival order, each cell with its data and final-cell flag unchanged. `out_valid` is 1 exactly when at least one fully stored packet is queued.
- R3: `cell_count` equals the number of cells held: cells of stored packets not yet sent or skipped, plus cells already accepted for a packet still arriving. It never exceeds 2^CELL_AW.
- R4: When a cell arrives (not during a discard) while `cell_count` equals 2^CELL_AW, `tail_drop` pulses in that cycle and every accepted cell of that packet is released. Further cells up to and including its final cell are ignored, and no cell of that packet is ever output.
- R5: When a packet's final cell arrives while 2^PKT_AW packets are already stored, the whole packet is dropped as in R4 and `tail_drop` pulses.
- R6: On a head drop, `head_drop` is 1 in the cycle the current packet's final cell is taken. In the next cycle the output shows the first cell of the packet after the skipped one, with no idle cycle.
- R7: A packet boundary is eligible when a final cell is taken while `drop_en` is 1 and `cell_count` is greater than 2^(CELL_AW-1). A policy phase bit, 0 after reset, toggles at each eligible boundary. A head drop is taken only at an eligible boundary where the phase is 1.
- R8: No head drop is taken unless at least two stored packets follow the current one. A head drop never occurs in the middle of a packet.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output cell holds and stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A cell is presented this cycle |
| in_data | input | DATA_W | Cell payload |
| in_last | input | 1 | Cell is the final one of its packet |
| drop_en | input | 1 | Enables the head-drop policy |
| out_ready | input | 1 | Consumer takes the output cell this cycle |
| out_valid | output | 1 | An output cell is available |
| out_data | output | DATA_W | Output cell payload |
| out_last | output | 1 | Output cell is the final one of its packet |
| head_drop | output | 1 | The next packet is skipped at this boundary |
| tail_drop | output | 1 | The arriving packet is discarded this cycle |
| cell_count | output | CELL_AW+1 | Cells currently held |

## Verification
`tail_drop`, `head_drop` and the output cell are combinational. They are due in the same cycle as the inputs and the registered state that cause them. A cell accepted with its packet's final flag becomes visible at the output one edge later. `cell_count` and the effect of a skip also show after one edge. The bench drives inputs just after the falling edge and compares all outputs one nanosecond later against a queue model that holds the pre-edge state. Only after that comparison does it advance the model by one edge, so every result is checked in the cycle it is due.

// File: rtl/cell_pkt_queue.sv
module cell_pkt_queue #(
  parameter int DATA_W  = 8,
  parameter int CELL_AW = 4,
  parameter int PKT_AW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              drop_en,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              head_drop,
  output logic              tail_drop,
  output logic [CELL_AW:0]  cell_count
);
  localparam int DEPTH  = 1 << CELL_AW;
  localparam int PDEPTH = 1 << PKT_AW;
  localparam int CP     = CELL_AW + 1;
  localparam int PP     = PKT_AW + 1;

  logic [DATA_W:0] cmem [DEPTH];
  logic [CP-1:0]   pmem [PDEPTH];

  logic [CP-1:0] wp, rp, pkt_start;
  logic [PP-1:0] dw, dr;
  logic mid, discard, phase;

  wire [PP-1:0] pkts      = dw - dr;
  wire [PP-1:0] dr_skip   = dr + PP'(2);
  wire          ring_full = cell_count == CP'(DEPTH);
  wire          desc_full = pkts == PP'(PDEPTH);
  wire          take      = in_valid && !discard;
  wire          reject    = take && (ring_full || (in_last && desc_full));
  wire          accept    = take && !reject;
  wire [CP-1:0] start_now = mid ? pkt_start : wp;

  wire fire     = out_valid && out_ready;
  wire boundary = fire && out_last;
  wire eligible = boundary && drop_en && (cell_count > CP'(DEPTH / 2));

  assign cell_count = wp - rp;
  assign out_valid  = dw != dr;
  assign {out_last, out_data} = cmem[rp[CELL_AW-1:0]];
  assign tail_drop  = reject;
  assign head_drop  = eligible && phase && (pkts >= PP'(3));

  always_ff @(posedge clk) begin
    if (accept) begin
      cmem[wp[CELL_AW-1:0]] <= {in_last, in_data};
      if (in_last) pmem[dw[PKT_AW-1:0]] <= start_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp        <= '0;
      pkt_start <= '0;
      dw        <= '0;
      mid       <= 1'b0;
      discard   <= 1'b0;
    end else begin
      if (accept) begin
        wp <= wp + CP'(1);
        if (in_last) begin
          dw  <= dw + PP'(1);
          mid <= 1'b0;
        end else begin
          mid       <= 1'b1;
          pkt_start <= start_now;
        end
      end else if (reject) begin
        wp      <= start_now;
        mid     <= 1'b0;
        discard <= !in_last;
      end else if (discard && in_valid && in_last) begin
        discard <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp    <= '0;
      dr    <= '0;
      phase <= 1'b0;
    end else begin
      if (eligible) phase <= !phase;
      if (fire) begin
        if (head_drop) begin
          rp <= pmem[dr_skip[PKT_AW-1:0]];
          dr <= dr_skip;
        end else begin
          rp <= rp + CP'(1);
          if (boundary) dr <= dr + PP'(1);
        end
      end
    end
  end
endmodule

module cell_pkt_queue_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5,
  parameter int DEPTH  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_last,
  input logic [DATA_W-1:0] out_data,
  input logic              head_drop,
  input logic              tail_drop,
  input logic [CNT_W-1:0]  cell_count
);
  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_count <= CNT_W'(DEPTH));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  // R8
  skip_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_drop |-> out_valid && out_ready && out_last);
  // R2
  packet_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid);
  // R6
  no_gap_after_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_drop |=> out_valid);
  // R4
  tail_needs_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_drop |-> in_valid);
endmodule

bind cell_pkt_queue cell_pkt_queue_chk #(.DATA_W(DATA_W), .CNT_W(CELL_AW + 1), .DEPTH(1 << CELL_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_ready(out_ready), .out_last(out_last), .out_data(out_data),
  .head_drop(head_drop), .tail_drop(tail_drop), .cell_count(cell_count)
);

// File: tb/test_cell_pkt_queue.sv
`timescale 1ns/1ps
module test_cell_pkt_queue;
  localparam int DATA_W = 8, CELL_AW = 4, PKT_AW = 3;
  localparam int DEPTH = 1 << CELL_AW, PDEPTH = 1 << PKT_AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, drop_en = 1'b0, out_ready = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic out_valid, out_last, head_drop, tail_drop;
  logic [DATA_W-1:0] out_data;
  logic [CELL_AW:0] cell_count;

  cell_pkt_queue #(.DATA_W(DATA_W), .CELL_AW(CELL_AW), .PKT_AW(PKT_AW)) i_cell_pkt_queue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .drop_en(drop_en), .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .head_drop(head_drop), .tail_drop(tail_drop), .cell_count(cell_count));

  always #5 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [DATA_W:0] cq[$];
  logic [DATA_W:0] part[$];
  int plen[$];
  bit mdisc = 0, mphase = 0;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_count();
    return cq.size() + part.size();
  endfunction

  task automatic step(input bit v, input logic [DATA_W-1:0] d, input bit l,
                      input bit de, input bit rdy);
    int cnt, n;
    bit ov, olast, fire, elig, hd, rej;
    logic [DATA_W:0] c;
    @(negedge clk);
    in_valid = v; in_data = d; in_last = l; drop_en = de; out_ready = rdy;
    #1;
    cnt   = exp_count();
    ov    = plen.size() > 0;
    olast = ov ? cq[0][DATA_W] : 1'b0;
    fire  = ov && rdy;
    elig  = fire && olast && de && (cnt > DEPTH / 2);
    hd    = elig && mphase && (plen.size() >= 3);
    rej   = v && !mdisc && ((cnt == DEPTH) || (l && plen.size() == PDEPTH));
    chk("R2 out_valid", int'(out_valid), int'(ov));
    if (ov) begin
      chk("R2 R9 out_data", int'(out_data), int'(cq[0][DATA_W-1:0]));
      chk("R2 out_last", int'(out_last), int'(olast));
    end
    chk("R3 cell_count", int'(cell_count), cnt);
    chk("R4 R5 tail_drop", int'(tail_drop), int'(rej));
    chk("R6 R7 R8 head_drop", int'(head_drop), int'(hd));
    if (fire) begin
      c = cq.pop_front();
      if (c[DATA_W]) begin
        void'(plen.pop_front());
        if (hd) begin
          n = plen.pop_front();
          repeat (n) void'(cq.pop_front());
        end
      end
    end
    if (elig) mphase = !mphase;
    if (v) begin
      if (mdisc) begin
        if (l) mdisc = 0;
      end else if (rej) begin
        part.delete();
        mdisc = !l;
      end else begin
        part.push_back({l, d});
        if (l) begin
          foreach (part[i]) cq.push_back(part[i]);
          plen.push_back(part.size());
          part.delete();
        end
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20121026);
    repeat (3) @(negedge clk);
    #1;
    chk("R1 out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    #1;
    chk("R1 cell_count", int'(cell_count), 0);
    chk("R1 out_valid after release", int'(out_valid), 0);

    // R4: oversized packet with the consumer stalled
    for (int i = 0; i < 20; i++) step(1, 8'(i), i == 19, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R4 nothing kept", int'(cell_count), 0);

    // R5: fill the descriptor ring with one-cell packets, then one more
    for (int i = 0; i <= PDEPTH; i++) step(1, 8'(8'h40 + i), 1, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R5 descriptors full", int'(cell_count), PDEPTH);
    for (int i = 0; i < PDEPTH + 2; i++) step(0, 0, 0, 0, 1);
    chk("R2 drained", int'(out_valid), 0);

    // R6 R7: three-cell packets, stalled, then drained with the policy on
    for (int i = 0; i < 15; i++) step(1, 8'(8'h80 + i), (i % 3) == 2, 0, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1, 1);
    chk("R6 queue empty after skips", int'(cell_count), 0);

    // random segments
    for (int s = 0; s < 12; s++) begin
      int pv, pr, pl;
      bit de;
      pv = 30 + (s * 7) % 70;
      pr = 20 + (s * 13) % 80;
      pl = 5 + (s * 11) % 40;
      de = s[0];
      for (int k = 0; k < 1500; k++)
        step(($urandom % 100) < pv, 8'($urandom), ($urandom % 100) < pl, de,
             ($urandom % 100) < pr);
    end
    for (int k = 0; k < 40; k++) step(0, 0, 0, 0, 1);
    chk("R2 final empty", int'(out_valid), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule